// File: doc/BRIEF.md
# Fixed-Ratio Bi-Level Pixel Reducer

This block shrinks a scanned bi-level image along the scan line by keeping some incoming pixels and discarding the rest. It never interpolates or averages. The pixel density along the line is 8 pixels per millimetre. A two-bit mode input selects one of four ratios. Three ratios map one paper width onto a narrower one: keep 13 of 15, keep 9 of 11, or keep 12 of 17. The fourth ratio passes every pixel through.

The kept pixels are spread evenly along each line. A per-pixel accumulator adds the ratio numerator on every valid pixel. The pixel is kept when the running sum reaches the denominator, and the denominator is then subtracted. A second accumulator advances once per line with the same ratio and drives a per-line keep flag. The feed-direction logic uses that flag to apply the same reduction to whole lines.

Input pixels arrive with a valid qualifier and a one-cycle line-start strobe. Output pixels leave with their own valid qualifier. The mode is sampled only at a line start.

Top module: `pixdrop_reducer`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `out_valid` and `line_keep` are low.
- R2: Mode 0 keeps every valid pixel, and every line has `line_keep` high.
- R3: Mode 1 keeps the i-th valid pixel of a line (i counted from 1) exactly when floor(13i/15) > floor(13(i-1)/15).
- R4: Mode 2 keeps the i-th valid pixel of a line exactly when floor(9i/11) > floor(9(i-1)/11).
- R5: Mode 3 keeps the i-th valid pixel of a line exactly when floor(12i/17) > floor(12(i-1)/17).
- R6: A kept pixel appears on `out_pix` with `out_valid` high one clock after it was presented. Its value is unchanged and input order is preserved. Dropped pixels produce no output.
- R7: Pixel numbering restarts at 1 at every `line_start`, including after a partial line. A valid pixel presented in the same cycle as `line_start` is pixel 1 of the new line.
- R8: `mode_sel` is sampled only in a `line_start` cycle. A change in the middle of a line has no effect on that line.
- R9: `line_keep` is updated on the clock that samples `line_start` and holds until the next `line_start`. With ratio n/d, the k-th line is kept exactly when floor(nk/d) > floor(n(k-1)/d).
- R10: Line numbering restarts at 1 when the mode sampled at a `line_start` differs from the mode of the previous line. The mode in force after reset is 0.
- R11: A cycle with `pix_valid` low advances no count and yields `out_valid` low on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Ratio: 0 all, 1 13/15, 2 9/11, 3 12/17 |
| line_start | input | 1 | One-cycle strobe opening a new line |
| pix_valid | input | 1 | Input pixel qualifier |
| pix_in | input | PIX_W | Input pixel |
| out_valid | output | 1 | Output pixel qualifier |
| out_pix | output | PIX_W | Output pixel |
| line_keep | output | 1 | Current line is kept in the feed direction |

## Verification
The bench drives each ratio with a pixel pattern that differs from one position to the next. A design that drops the wrong positions therefore delivers wrong data or the wrong count to the scoreboard. It sends a partial line followed by a line whose first pixel shares the `line_start` cycle. A design that keeps its count across lines, or that loses the same-cycle pixel, gives a shifted drop pattern. It changes `mode_sel` in the middle of a line, so a design that samples the mode early would switch ratio too soon. A sequence of short lines, which switches mode and back, checks `line_keep` against the line formula. A design that does not restart the line count on a mode change will overshoot the new denominator.

// File: rtl/pixdrop_pkg.sv
package pixdrop_pkg;
  localparam int RATIO_W = 5;

  typedef enum logic [1:0] {
    MODE_ALL   = 2'd0,
    MODE_13_15 = 2'd1,
    MODE_9_11  = 2'd2,
    MODE_12_17 = 2'd3
  } drop_mode_e;

  typedef struct packed {
    logic [RATIO_W-1:0] num;
    logic [RATIO_W-1:0] den;
  } ratio_t;

  function automatic ratio_t ratio_of(drop_mode_e m);
    ratio_t r;
    case (m)
      MODE_13_15: begin r.num = RATIO_W'(13); r.den = RATIO_W'(15); end
      MODE_9_11:  begin r.num = RATIO_W'(9);  r.den = RATIO_W'(11); end
      MODE_12_17: begin r.num = RATIO_W'(12); r.den = RATIO_W'(17); end
      default:    begin r.num = RATIO_W'(1);  r.den = RATIO_W'(1);  end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/pixdrop_ratio_sel.sv
module pixdrop_ratio_sel
  import pixdrop_pkg::*;
(
  input  drop_mode_e mode,
  output ratio_t     ratio
);
  assign ratio = ratio_of(mode);
endmodule

// File: rtl/pixdrop_accum.sv
// Even-spread selector: adds num per step, fires when the sum reaches den.
module pixdrop_accum #(
  parameter int VAL_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             step,
  input  logic [VAL_W-1:0] num,
  input  logic [VAL_W-1:0] den,
  output logic             take
);
  localparam int ACC_W = VAL_W + 1;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] base;
  logic [ACC_W-1:0] sum;

  always_comb begin
    base = restart ? '0 : acc_q;
    sum  = base + ACC_W'(num);
    take = step && (sum >= ACC_W'(den));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else if (step) begin
      acc_q <= take ? (sum - ACC_W'(den)) : sum;
    end else if (restart) begin
      acc_q <= '0;
    end
  end
endmodule

// File: rtl/pixdrop_reducer.sv
module pixdrop_reducer
  import pixdrop_pkg::*;
#(
  parameter int PIX_W = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode_sel,
  input  logic             line_start,
  input  logic             pix_valid,
  input  logic [PIX_W-1:0] pix_in,
  output logic             out_valid,
  output logic [PIX_W-1:0] out_pix,
  output logic             line_keep
);
  drop_mode_e active_q;
  drop_mode_e cur_mode;
  ratio_t     cur_ratio;
  logic       mode_change;
  logic       pix_take;
  logic       line_take;

  // The mode offered with line_start governs that same cycle.
  always_comb begin
    cur_mode    = line_start ? drop_mode_e'(mode_sel) : active_q;
    mode_change = line_start && (drop_mode_e'(mode_sel) != active_q);
  end

  pixdrop_ratio_sel u_sel (
    .mode  (cur_mode),
    .ratio (cur_ratio)
  );

  pixdrop_accum #(.VAL_W(RATIO_W)) u_pix_acc (
    .clk     (clk),
    .rst     (rst),
    .restart (line_start),
    .step    (pix_valid),
    .num     (cur_ratio.num),
    .den     (cur_ratio.den),
    .take    (pix_take)
  );

  pixdrop_accum #(.VAL_W(RATIO_W)) u_line_acc (
    .clk     (clk),
    .rst     (rst),
    .restart (mode_change),
    .step    (line_start),
    .num     (cur_ratio.num),
    .den     (cur_ratio.den),
    .take    (line_take)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q  <= MODE_ALL;
      out_valid <= 1'b0;
      out_pix   <= '0;
      line_keep <= 1'b0;
    end else begin
      out_valid <= pix_take;
      if (pix_valid) out_pix <= pix_in;
      if (line_start) begin
        active_q  <= drop_mode_e'(mode_sel);
        line_keep <= line_take;
      end
    end
  end
endmodule

// File: rtl/pixdrop_checks.sv
module pixdrop_checks #(
  parameter int PIX_W = 1
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       mode_sel,
  input logic             line_start,
  input logic             pix_valid,
  input logic [PIX_W-1:0] pix_in,
  input logic             out_valid,
  input logic [PIX_W-1:0] out_pix,
  input logic             line_keep
);
  // R1
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!out_valid && !line_keep));

  // R6
  a_r6_needs_input: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(pix_valid));

  // R6
  a_r6_value_kept: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_pix == $past(pix_in)));

  // R11
  a_r11_idle_silent: assert property (@(posedge clk) disable iff (rst)
    !pix_valid |=> !out_valid);

  // R9
  a_r9_flag_holds: assert property (@(posedge clk) disable iff (rst)
    !line_start |=> $stable(line_keep));

  // R2
  a_r2_all_line_kept: assert property (@(posedge clk) disable iff (rst)
    (line_start && mode_sel == 2'd0) |=> line_keep);

  // R2
  a_r2_all_pix_out: assert property (@(posedge clk) disable iff (rst)
    (line_start && pix_valid && mode_sel == 2'd0) |=> out_valid);
endmodule

bind pixdrop_reducer pixdrop_checks #(.PIX_W(PIX_W)) u_chk (.*);

// File: tb/sim_pixdrop_reducer.sv
`timescale 1ns/1ps
module sim_pixdrop_reducer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode_sel = 2'd0;
  logic       line_start = 1'b0;
  logic       pix_valid = 1'b0;
  logic [0:0] pix_in = 1'b0;
  logic       out_valid;
  logic [0:0] out_pix;
  logic       line_keep;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  string cur_req = "R1";
  logic [0:0] exp_q[$];
  int line_num = 0;
  int line_idx = 0;
  logic [1:0] prev_mode = 2'd0;

  always #2.5 clk = ~clk;

  pixdrop_reducer #(.PIX_W(1)) u0 (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .line_start(line_start),
    .pix_valid(pix_valid), .pix_in(pix_in), .out_valid(out_valid),
    .out_pix(out_pix), .line_keep(line_keep)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void ratio(logic [1:0] m, output int n, output int d);
    case (m)
      2'd1: begin n = 13; d = 15; end
      2'd2: begin n = 9;  d = 11; end
      2'd3: begin n = 12; d = 17; end
      default: begin n = 1; d = 1; end
    endcase
  endfunction

  function automatic bit kept(int k, int n, int d);
    return ((k * n) / d) > (((k - 1) * n) / d);
  endfunction

  function automatic logic [0:0] pat(int ln, int i);
    return ((i * 3 + ln) % 5) < 2;
  endfunction

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && out_valid && !done) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, {cur_req, " R6 unexpected output"}, 1, 0);
      end else begin
        logic [0:0] e;
        e = exp_q.pop_front();
        chk(out_pix == e, {cur_req, " R6 pixel"}, int'(out_pix), int'(e));
      end
    end
  end

  task automatic run_line(input logic [1:0] m, input int npix, input int gap_every,
                          input bit first_with_start, input int switch_at,
                          input logic [1:0] switch_mode);
    int n, d, idx;
    bit lk_exp;
    ratio(m, n, d);
    line_num++;
    if (m != prev_mode) line_idx = 1; else line_idx++;
    prev_mode = m;
    lk_exp = kept(line_idx, n, d);
    idx = 0;
    @(posedge clk); #1;
    line_start = 1'b1; mode_sel = m; pix_valid = 1'b0;
    if (first_with_start && npix > 0) begin
      idx++;
      pix_in = pat(line_num, idx); pix_valid = 1'b1;
      if (kept(idx, n, d)) exp_q.push_back(pat(line_num, idx));
    end
    @(posedge clk); #1;
    line_start = 1'b0; pix_valid = 1'b0;
    @(negedge clk);
    chk(line_keep == lk_exp, "R9/R10 line_keep", int'(line_keep), int'(lk_exp));
    while (idx < npix) begin
      @(posedge clk); #1;
      if (switch_at == idx) mode_sel = switch_mode;
      if (gap_every > 0 && (idx % gap_every) == 0) begin
        pix_valid = 1'b0;   // R11 idle cycle
        @(posedge clk); #1;
      end
      idx++;
      pix_in = pat(line_num, idx); pix_valid = 1'b1;
      if (kept(idx, n, d)) exp_q.push_back(pat(line_num, idx));
    end
    @(posedge clk); #1;
    pix_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    // R1: reset holds outputs low even with input activity
    pix_valid = 1'b1; pix_in = 1'b1; line_start = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!out_valid, "R1 out_valid in reset", int'(out_valid), 0);
    chk(!line_keep, "R1 line_keep in reset", int'(line_keep), 0);
    #1 rst = 1'b0; pix_valid = 1'b0; line_start = 1'b0;
    @(negedge clk);
    chk(!out_valid, "R1 out_valid after reset", int'(out_valid), 0);
    chk(!line_keep, "R1 line_keep after reset", int'(line_keep), 0);

    cur_req = "R2";  run_line(2'd0, 20, 0, 1'b0, -1, 2'd0);
    cur_req = "R3";  run_line(2'd1, 32, 0, 1'b0, -1, 2'd0);
    cur_req = "R4";  run_line(2'd2, 25, 4, 1'b0, -1, 2'd0);
    cur_req = "R5";  run_line(2'd3, 36, 0, 1'b0, -1, 2'd0);
    cur_req = "R8";  run_line(2'd1, 30, 0, 1'b0, 10, 2'd3);
    cur_req = "R7";  run_line(2'd2, 5, 0, 1'b0, -1, 2'd0);
    run_line(2'd2, 12, 0, 1'b1, -1, 2'd0);
    cur_req = "R9";
    for (int k = 0; k < 12; k++) run_line(2'd2, 3, 0, 1'b0, -1, 2'd0);
    cur_req = "R10";
    run_line(2'd3, 4, 0, 1'b0, -1, 2'd0);
    run_line(2'd3, 2, 0, 1'b0, -1, 2'd0);
    run_line(2'd2, 3, 0, 1'b0, -1, 2'd0);
    run_line(2'd2, 3, 0, 1'b0, -1, 2'd0);
    run_line(2'd0, 3, 0, 1'b1, -1, 2'd0);

    cur_req = "R11";
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!out_valid, "R11 idle output", int'(out_valid), 0);
    chk(exp_q.size() == 0, "R6 pending kept pixels", exp_q.size(), 0);
    finish_run();
  end
endmodule